// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock (normally the VCO output of a frequency synthesizer) by a programmable ratio of 16·N + A. The divider does not use one wide counter running at the input rate. A small prescaler counts either 16 or 17 input clocks per step. A main counter counts N prescaler steps per output period. A swallow counter keeps the prescaler in its 17-count mode for the first A steps of each period. The result is one output pulse, one input clock wide, every 16·N + A input clocks. The pulse goes to a phase comparator, and a second, separately registered copy drives a monitor pin.

The ratio settings are checked against the legal range, which requires N above 16 and N above A. Any other setting raises an error flag and is not used. New settings are applied only where one output period ends and the next begins, so no period is ever cut short. A run enable stops the divider and clears its counters. When the enable returns, counting restarts from a known state.

Top module: `psw_divider`

## Requirements
- R1: While running with an active ratio (N, A), consecutive `div_pulse` assertions are exactly 16·N + A input clocks apart. The first pulse after enabling also comes 16·N + A clocks after the first enabled clock edge.
- R2: `div_pulse` is high for exactly one input clock per period, and `mon_pulse` is high in exactly the same cycles as `div_pulse`.
- R3: Within each output period, the prescaler counts 17 input clocks per step for the first A steps and 16 input clocks per step for the remaining N − A steps. Its count reaches 16 only during a swallowed step.
- R4: A change of `n_set`/`a_set` during a period does not alter that period. The new ratio governs the periods that start after the next pulse.
- R5: `cfg_err` is high one clock after `n_set`/`a_set` present a setting with N ≤ 16 or N ≤ A, and low one clock after a valid setting is presented. The boundary setting N = 16, A = 0 counts as invalid.
- R6: An invalid setting is never loaded. The divider keeps producing periods at the last valid ratio.
- R7: While `run_en` is low, no pulses are issued and all counters stay cleared. While idle, a valid setting is loaded at once, so the first period after `run_en` rises is exact.
- R8: During reset, `div_pulse`, `mon_pulse` and `cfg_err` are low, and the active ratio is N = 17, A = 0 (272 clocks). If no valid setting is ever presented, the divider runs at 272.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High: divider runs; low: divider idles with cleared counters |
| n_set | input | 14 | Main counter setting N |
| a_set | input | 4 | Swallow counter setting A |
| div_pulse | output | 1 | One-clock pulse per divided period, to the phase comparator |
| mon_pulse | output | 1 | Monitor copy of the divided pulse |
| cfg_err | output | 1 | High while the presented setting is illegal |

## Verification
On every cycle, the bound assertions check the following: the prescaler reaches its seventeenth count only while steps are being swallowed; the swallow count never passes A; the active ratio is always legal; the active ratio changes only at a period end or while idle; and the pulse is one clock wide and matched by the monitor. The idle behaviour (counters clear, no pulse) is also asserted every cycle. Only the bench scenarios can show the actual period lengths for several (N, A) pairs. The same holds for the first period after enabling, a ratio change that lands mid-period, holding the ratio through invalid settings, and the default ratio after reset.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int PSD_N_W      = 14;
    localparam int PSD_A_W      = 4;
    localparam int PSD_PRE_BASE = 16;
    localparam int PSD_DEF_N    = 17;
    localparam int PSD_DEF_A    = 0;

    typedef struct packed {
        logic pulse;
        logic mon;
    } psd_out_t;
endpackage

// File: rtl/psd_cfg_guard.sv
module psd_cfg_guard #(
    parameter int N_W      = 14,
    parameter int A_W      = 4,
    parameter int PRE_BASE = 16,
    parameter int DEF_N    = 17,
    parameter int DEF_A    = 0
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic           period_end,
    input  logic [N_W-1:0] n_in,
    input  logic [A_W-1:0] a_in,
    output logic [N_W-1:0] act_n,
    output logic [A_W-1:0] act_a,
    output logic           err
);
    typedef struct packed {
        logic [N_W-1:0] n;
        logic [A_W-1:0] a;
        logic           err;
    } guard_t;

    guard_t st_d, st_q;
    logic   legal;
    logic   may_load;

    always_comb begin
        legal    = (n_in > N_W'(PRE_BASE)) && (n_in > {{(N_W-A_W){1'b0}}, a_in});
        may_load = !run_en || period_end;
        st_d     = st_q;
        st_d.err = !legal;
        if (may_load && legal) begin
            st_d.n = n_in;
            st_d.a = a_in;
        end
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) begin
            st_q.n   <= N_W'(DEF_N);
            st_q.a   <= A_W'(DEF_A);
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act_n = st_q.n;
    assign act_a = st_q.a;
    assign err   = st_q.err;
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int PRE_BASE = 16,
    localparam int PRE_W   = $clog2(PRE_BASE + 1)
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             mod_hi,
    output logic             tick,
    output logic [PRE_W-1:0] cnt
);
    logic [PRE_W-1:0] cnt_d, cnt_q;
    logic [PRE_W-1:0] last;

    always_comb begin
        last  = mod_hi ? PRE_W'(PRE_BASE) : PRE_W'(PRE_BASE - 1);
        tick  = run_en && (cnt_q == last);
        cnt_d = cnt_q;
        if (!run_en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + PRE_W'(1);
        end
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/psd_step_ctrl.sv
module psd_step_ctrl #(
    parameter int N_W = 14,
    parameter int A_W = 4
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic           tick,
    input  logic [N_W-1:0] act_n,
    input  logic [A_W-1:0] act_a,
    output logic           mod_hi,
    output logic           period_end,
    output logic [N_W-1:0] main_cnt,
    output logic [A_W-1:0] sw_cnt
);
    typedef struct packed {
        logic [N_W-1:0] main;
        logic [A_W-1:0] sw;
    } step_t;

    step_t st_d, st_q;
    logic  last_step;

    always_comb begin
        mod_hi     = st_q.sw < act_a;
        last_step  = st_q.main == (act_n - N_W'(1));
        period_end = tick && last_step;
        st_d       = st_q;
        if (!run_en || period_end) begin
            st_d.main = '0;
            st_d.sw   = '0;
        end else if (tick) begin
            st_d.main = st_q.main + N_W'(1);
            if (mod_hi) st_d.sw = st_q.sw + A_W'(1);
        end
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign main_cnt = st_q.main;
    assign sw_cnt   = st_q.sw;
endmodule

// File: rtl/psw_divider.sv
module psw_divider
    import psd_pkg::*;
#(
    parameter int N_W      = PSD_N_W,
    parameter int A_W      = PSD_A_W,
    parameter int PRE_BASE = PSD_PRE_BASE,
    parameter int DEF_N    = PSD_DEF_N,
    parameter int DEF_A    = PSD_DEF_A,
    parameter bit MON_REG  = 1'b1,
    localparam int PRE_W   = $clog2(PRE_BASE + 1)
) (
    input  logic           clk_in,
    input  logic           rst_n,
    input  logic           run_en,
    input  logic [N_W-1:0] n_set,
    input  logic [A_W-1:0] a_set,
    output logic           div_pulse,
    output logic           mon_pulse,
    output logic           cfg_err
);
    logic [N_W-1:0]   act_n;
    logic [A_W-1:0]   act_a;
    logic             mod_hi;
    logic             tick;
    logic             period_end;
    logic [PRE_W-1:0] pre_cnt;
    logic [N_W-1:0]   main_cnt;
    logic [A_W-1:0]   sw_cnt;

    psd_cfg_guard #(
        .N_W(N_W), .A_W(A_W), .PRE_BASE(PRE_BASE), .DEF_N(DEF_N), .DEF_A(DEF_A)
    ) u_guard (
        .clk_in(clk_in), .rst_n(rst_n), .run_en(run_en), .period_end(period_end),
        .n_in(n_set), .a_in(a_set), .act_n(act_n), .act_a(act_a), .err(cfg_err)
    );

    psd_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
        .clk_in(clk_in), .rst_n(rst_n), .run_en(run_en), .mod_hi(mod_hi),
        .tick(tick), .cnt(pre_cnt)
    );

    psd_step_ctrl #(.N_W(N_W), .A_W(A_W)) u_step (
        .clk_in(clk_in), .rst_n(rst_n), .run_en(run_en), .tick(tick),
        .act_n(act_n), .act_a(act_a), .mod_hi(mod_hi), .period_end(period_end),
        .main_cnt(main_cnt), .sw_cnt(sw_cnt)
    );

    psd_out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.pulse = period_end;
        out_d.mon   = period_end;
    end

    always_ff @(posedge clk_in or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign div_pulse = out_q.pulse;

    generate
        if (MON_REG) begin : g_mon_reg
            assign mon_pulse = out_q.mon;
        end else begin : g_mon_wire
            assign mon_pulse = out_q.pulse;
        end
    endgenerate
endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int N_W      = 14,
    parameter int A_W      = 4,
    parameter int PRE_BASE = 16,
    parameter int PRE_W    = 5
) (
    input logic             clk_in,
    input logic             rst_n,
    input logic             run_en,
    input logic             div_pulse,
    input logic             mon_pulse,
    input logic             period_end,
    input logic [PRE_W-1:0] pre_cnt,
    input logic [N_W-1:0]   main_cnt,
    input logic [A_W-1:0]   sw_cnt,
    input logic [N_W-1:0]   act_n,
    input logic [A_W-1:0]   act_a
);
    AST_PULSE_ONE_CLOCK: assert property (@(posedge clk_in) disable iff (!rst_n)
        div_pulse |=> !div_pulse); // R2
    AST_MON_MATCH: assert property (@(posedge clk_in) disable iff (!rst_n)
        mon_pulse == div_pulse); // R2
    AST_SEVENTEEN_ONLY_SWALLOW: assert property (@(posedge clk_in) disable iff (!rst_n)
        (pre_cnt == PRE_W'(PRE_BASE)) |-> (sw_cnt < act_a)); // R3
    AST_SWALLOW_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
        sw_cnt <= act_a); // R3
    AST_RATIO_FROZEN: assert property (@(posedge clk_in) disable iff (!rst_n)
        (run_en && !period_end) |=> $stable({act_n, act_a})); // R4
    AST_ACTIVE_LEGAL: assert property (@(posedge clk_in) disable iff (!rst_n)
        (act_n > N_W'(PRE_BASE)) && (act_n > {{(N_W-A_W){1'b0}}, act_a})); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk_in) disable iff (!rst_n)
        !run_en |=> !div_pulse); // R7
    AST_IDLE_CLEAR: assert property (@(posedge clk_in) disable iff (!rst_n)
        !run_en |=> (pre_cnt == '0 && main_cnt == '0 && sw_cnt == '0)); // R7
    AST_MAIN_BOUND: assert property (@(posedge clk_in) disable iff (!rst_n)
        main_cnt < act_n); // R1
endmodule

bind psw_divider psd_checker #(
    .N_W(N_W), .A_W(A_W), .PRE_BASE(PRE_BASE), .PRE_W(PRE_W)
) u_chk (
    .clk_in(clk_in), .rst_n(rst_n), .run_en(run_en), .div_pulse(div_pulse),
    .mon_pulse(mon_pulse), .period_end(period_end), .pre_cnt(pre_cnt),
    .main_cnt(main_cnt), .sw_cnt(sw_cnt), .act_n(act_n), .act_a(act_a)
);

// File: tb/psw_divider_test.sv
module psw_divider_test;
    logic        clk_in = 1'b0;
    logic        rst_n  = 1'b0;
    logic        run_en = 1'b0;
    logic [13:0] n_set  = 14'd3;
    logic [3:0]  a_set  = 4'd0;
    logic        div_pulse, mon_pulse, cfg_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    psw_divider uut (
        .clk_in(clk_in), .rst_n(rst_n), .run_en(run_en), .n_set(n_set),
        .a_set(a_set), .div_pulse(div_pulse), .mon_pulse(mon_pulse), .cfg_err(cfg_err)
    );

    always #10 clk_in = ~clk_in;

    always @(posedge clk_in) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles, expected under 190000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // {N, A, expected period}
    localparam logic [35:0] VEC [0:4] = '{
        {14'd17,   4'd0,  18'd272},
        {14'd17,   4'd15, 18'd287},
        {14'd20,   4'd5,  18'd325},
        {14'd100,  4'd9,  18'd1609},
        {14'd1000, 4'd7,  18'd16007}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_in);
        @(negedge clk_in);
    endtask

    // counts clocks until div_pulse is seen, starting from 'start'
    task automatic wait_pulse(input int start, output int cnt);
        cnt = start;
        for (int i = 0; i < 70000; i++) begin
            step();
            cnt++;
            if (div_pulse) begin
                if (mon_pulse !== 1'b1) chk(1'b0, "R2 monitor", 0, 1);
                return;
            end
        end
        cnt = -1;
    endtask

    initial begin
        int p;
        // R8 reset state
        #35;
        chk(div_pulse == 1'b0 && mon_pulse == 1'b0, "R8 pulses in reset", int'(div_pulse), 0);
        chk(cfg_err == 1'b0, "R8 cfg_err in reset", int'(cfg_err), 0);
        @(negedge clk_in);
        rst_n = 1'b1;
        step();
        chk(cfg_err == 1'b1, "R5 invalid N=3", int'(cfg_err), 1);
        // R8 default ratio with invalid inputs
        run_en = 1'b1;
        wait_pulse(0, p);
        chk(p == 272, "R8 default period", p, 272);
        step();
        chk(div_pulse == 1'b0 && mon_pulse == 1'b0, "R2 one clock wide", int'(div_pulse), 0);
        run_en = 1'b0;

        // table walk: R1 and R3 over several ratios
        for (int k = 0; k < 5; k++) begin
            int exp;
            run_en = 1'b0;
            n_set  = VEC[k][35:22];
            a_set  = VEC[k][21:18];
            exp    = int'(VEC[k][17:0]);
            step();
            step();
            chk(cfg_err == 1'b0, "R5 valid setting", int'(cfg_err), 0);
            run_en = 1'b1;
            wait_pulse(0, p);
            chk(p == exp, "R1 first period after enable (R7)", p, exp);
            wait_pulse(0, p);
            chk(p == exp, "R1 R3 steady period", p, exp);
            step();
            chk(div_pulse == 1'b0, "R2 pulse width", int'(div_pulse), 0);
        end

        // R4 mid-period change
        run_en = 1'b0;
        n_set = 14'd17; a_set = 4'd0;
        step();
        run_en = 1'b1;
        for (int i = 0; i < 100; i++) step();
        n_set = 14'd18; a_set = 4'd3;
        wait_pulse(100, p);
        chk(p == 272, "R4 in-flight period unchanged", p, 272);
        wait_pulse(0, p);
        chk(p == 291, "R4 new ratio next period", p, 291);

        // R5/R6 invalid settings held
        n_set = 14'd10; a_set = 4'd0;
        step();
        chk(cfg_err == 1'b1, "R5 N=10 flagged", int'(cfg_err), 1);
        wait_pulse(1, p);
        chk(p == 291, "R6 ratio held", p, 291);
        n_set = 14'd16; a_set = 4'd0;
        step();
        chk(cfg_err == 1'b1, "R5 boundary N=16", int'(cfg_err), 1);
        wait_pulse(1, p);
        chk(p == 291, "R6 held at N=16", p, 291);
        n_set = 14'd5; a_set = 4'd9;
        step();
        chk(cfg_err == 1'b1, "R5 N not above A", int'(cfg_err), 1);
        wait_pulse(1, p);
        chk(p == 291, "R6 held at N<A", p, 291);
        n_set = 14'd17; a_set = 4'd15;
        step();
        chk(cfg_err == 1'b0, "R5 err clears", int'(cfg_err), 0);
        wait_pulse(1, p);
        chk(p == 291, "R4 load waits for boundary", p, 291);
        wait_pulse(0, p);
        chk(p == 287, "R1 R3 N=17 A=15", p, 287);

        // R7 idle: no pulses, then exact restart
        for (int i = 0; i < 50; i++) step();
        run_en = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < 600; i++) begin
                step();
                if (div_pulse || mon_pulse) seen++;
            end
            chk(seen == 0, "R7 no pulses while idle", seen, 0);
        end
        run_en = 1'b1;
        wait_pulse(0, p);
        chk(p == 287, "R7 exact restart", p, 287);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule